// File: doc/BRIEF.md
# Serial Audio DAC Word Transmitter

This block sits on the host side of an 18-bit serial-input audio converter and turns parallel two's-complement samples into the three-wire stream that such a converter expects. Samples arrive on a valid/ready stream. For each accepted sample the block produces one frame on three outputs: a bit clock, a serial data line and a latch strobe. The receiver shifts data on rising bit-clock edges and moves the finished word into its output latch when the strobe falls.

The bit clock comes from the system clock through an even divider ratio `CLK_DIV`. It runs low for the first half of each bit period and high for the second half. Data and strobe change only at the system edge where the bit clock falls, so the receiver gets half a bit period of setup and hold around each rising edge. A frame is `FRAME_LEN` bit periods long. The first `FRAME_LEN - WORD_W` periods are padding and carry a zero data bit. The sample bits fill the tail of the frame, most significant bit first.

Back-pressure rule: `s_ready` is high whenever no frame is running. It is also high in the final system cycle of a frame, so a sample that is waiting then starts the next frame with no gap. At all other times `s_ready` is low, and `s_valid` and `s_data` are ignored. If no sample is waiting when a frame ends, the bit clock is parked low and the strobe stays low until a new sample arrives.

Top module: `dac_word_tx`

## Requirements
- R1: While `rst_n` is low, `bclk`, `sdata` and `latch_en` are 0 and `s_ready` is 1.
- R2: A sample is taken on a clock edge where `s_valid` and `s_ready` are both 1. `s_ready` is 0 during a running frame, except in the frame's last system cycle (cycle `FRAME_LEN*CLK_DIV-1` counted from 0 after the accepting edge), where it is 1.
- R3: Within a frame, every bit period lasts `CLK_DIV` system cycles. `bclk` is 0 for the first `CLK_DIV/2` of them and 1 for the rest, and a frame contains exactly `FRAME_LEN` such periods.
- R4: Bit periods 0 to `FRAME_LEN-WORD_W-1` of a frame carry `sdata`=0. Period `FRAME_LEN-WORD_W+k` carries sample bit `WORD_W-1-k`, so the most significant bit comes first and the least significant bit ends the frame.
- R5: `sdata` and `latch_en` change only at system edges where `bclk` goes from 1 to 0.
- R6: `latch_en` rises at the start of the period that carries the most significant bit. It falls on the `bclk` falling edge that ends the least significant bit's period, after at least one `bclk` rising edge with `latch_en` high.
- R7: Between a fall of `latch_en` and its next rise, at least one `bclk` rising edge occurs with `latch_en` low. This holds even when the bit clock was stopped between words.
- R8: A receiver that shifts `sdata` in on rising `bclk` edges and captures its last `WORD_W` bits when `latch_en` falls gets every submitted sample, in order. This includes the codes 0x1FFFF (positive full scale), 0x00000 (zero), 0x3FFFF (one step below zero) and 0x20000 (negative full scale).
- R9: With no frame running, `bclk`, `sdata` and `latch_en` stay 0.
- R10: `s_valid` and `s_data` presented while `s_ready` is 0 have no effect on the frame in progress and are not taken as a sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Block can take a sample this cycle |
| s_data | input | WORD_W | Two's-complement sample |
| bclk | output | 1 | Serial bit clock to the converter |
| sdata | output | 1 | Serial data, valid around rising `bclk` |
| latch_en | output | 1 | Latch strobe; its falling edge loads the word |

## Verification
The bench builds the block with `WORD_W`=18, `FRAME_LEN`=24 and `CLK_DIV`=4. A divide ratio of 4 gives each half of the bit clock two system cycles, so an early or late data or strobe change shows up as a phase error and cannot hide in a single-cycle half period. The six padding periods allow the strobe's low-time rule to be checked both across back-to-back frames and after an idle gap with a stopped clock. The full-scale and zero-crossing codes, sent back to back, exercise the ready window in the last cycle of a frame.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

  typedef struct packed {
    logic load;   // take a new sample, drive padding
    logic shift;  // present the next sample bit
    logic clear;  // frame over, park data low
  } shift_ctl_t;

endpackage

// File: rtl/dac_tx_clkdiv.sv
module dac_tx_clkdiv #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic bclk,
  output logic fall_tick
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(CLK_DIV - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  assign fall_tick = run && (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (cnt == CNT_LAST) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else begin
      if (cnt == CNT_MID) bclk <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end

  // R9: a stopped divider keeps the bit clock parked low
  assert_bclk_parked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> !bclk);

endmodule

// File: rtl/dac_tx_seq.sv
module dac_tx_seq
  import dac_tx_pkg::*;
#(
  parameter int WORD_W    = 18,
  parameter int FRAME_LEN = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic       fall_tick,
  input  logic       bclk,
  output logic       run,
  output logic       latch_en,
  output shift_ctl_t ctl
);
  localparam int LEAD = FRAME_LEN - WORD_W;
  localparam int SW   = $clog2(FRAME_LEN);
  localparam logic [SW-1:0] LAST_SLOT = SW'(FRAME_LEN - 1);
  localparam logic [SW-1:0] PRE_MSB   = SW'(LEAD - 1);
  localparam logic [SW-1:0] MSB_SLOT  = SW'(LEAD);

  logic [SW-1:0] slot;
  logic          busy;
  logic          last;
  logic          accept;

  assign last    = fall_tick && (slot == LAST_SLOT);
  assign s_ready = !busy || last;
  assign accept  = s_valid && s_ready;
  assign run     = busy;

  assign ctl.load  = accept;
  assign ctl.shift = fall_tick && (slot >= PRE_MSB) && !last;
  assign ctl.clear = last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      slot <= '0;
    end else if (last) begin
      busy <= 1'b0;
    end else if (fall_tick) begin
      slot <= slot + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               latch_en <= 1'b0;
    else if (last)                            latch_en <= 1'b0;
    else if (fall_tick && slot == PRE_MSB)    latch_en <= 1'b1;
  end

  // R5: the strobe moves only together with a falling bit clock
  assert_le_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(latch_en) |-> $fell(bclk));
  // R6: strobe rises entering the MSB period
  assert_le_rise_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_en) |-> (busy && slot == MSB_SLOT));
  // R6: strobe falls only when the LSB period ends
  assert_le_fall_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_en) |-> ($past(slot) == LAST_SLOT));
  // R2: a running frame not in its last cycle refuses samples
  assert_ready_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fall_tick) |-> !s_ready);

endmodule

// File: rtl/dac_tx_shift.sv
module dac_tx_shift
  import dac_tx_pkg::*;
#(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  shift_ctl_t        ctl,
  input  logic [WORD_W-1:0] din,
  input  logic              bclk,
  output logic              sdata
);
  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg  <= '0;
      sdata <= 1'b0;
    end else if (ctl.load) begin
      sreg  <= din;
      sdata <= 1'b0;
    end else if (ctl.shift) begin
      sdata <= sreg[WORD_W-1];
      sreg  <= {sreg[WORD_W-2:0], 1'b0};
    end else if (ctl.clear) begin
      sdata <= 1'b0;
    end
  end

  // R5: data moves only together with a falling bit clock
  assert_sdata_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $fell(bclk));

endmodule

// File: rtl/dac_word_tx.sv
module dac_word_tx
  import dac_tx_pkg::*;
#(
  parameter int WORD_W    = 18,
  parameter int FRAME_LEN = 24,
  parameter int CLK_DIV   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  output logic              bclk,
  output logic              sdata,
  output logic              latch_en
);
  generate
    if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("CLK_DIV must be even and at least 2");
    end
    if (FRAME_LEN <= WORD_W || WORD_W < 2) begin : g_bad_frame
      $error("FRAME_LEN must exceed WORD_W by at least one padding period");
    end
  endgenerate

  logic       run;
  logic       fall_tick;
  shift_ctl_t ctl;

  dac_tx_clkdiv #(.CLK_DIV(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .bclk(bclk), .fall_tick(fall_tick)
  );

  dac_tx_seq #(.WORD_W(WORD_W), .FRAME_LEN(FRAME_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .fall_tick(fall_tick), .bclk(bclk), .run(run), .latch_en(latch_en), .ctl(ctl)
  );

  dac_tx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .din(s_data), .bclk(bclk), .sdata(sdata)
  );

endmodule

// File: tb/dac_word_tx_tb.sv
module dac_word_tx_tb;
  localparam int W    = 18;
  localparam int F    = 24;
  localparam int D    = 4;
  localparam int LEAD = F - W;
  localparam int FC   = F * D;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         s_valid = 1'b0;
  logic [W-1:0] s_data = '0;
  logic         s_ready, bclk, sdata, latch_en;

  always #5 clk = ~clk;

  dac_word_tx #(.WORD_W(W), .FRAME_LEN(F), .CLK_DIV(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .bclk(bclk), .sdata(sdata), .latch_en(latch_en)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: frame time counter and expected word queue
  bit           m_busy = 0;
  int           m_t = 0;
  logic [W-1:0] m_word = '0;
  logic [W-1:0] expq[$];
  int           n_sent = 0;

  function automatic bit m_ready();
    return !m_busy || (m_t == FC - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0;
      m_t = 0;
    end else if (s_valid && m_ready()) begin
      m_busy = 1;
      m_t = 0;
      m_word = s_data;
      expq.push_back(s_data);
      n_sent++;
    end else if (m_busy) begin
      if (m_t == FC - 1) m_busy = 0;
      else m_t++;
    end
  end

  // per-cycle comparison, half a system period after each edge
  logic prev_bclk = 0, prev_sd = 0, prev_le = 0;
  always @(negedge clk) begin
    int slot, ph;
    bit e_bclk, e_sd, e_le, e_rdy;
    slot = m_t / D;
    ph = m_t % D;
    if (!rst_n) begin
      check(bclk == 0 && sdata == 0 && latch_en == 0, "R1", "reset outputs",
            {bclk, sdata, latch_en}, 0);
      check(s_ready == 1, "R1", "reset ready", s_ready, 1);
    end else begin
      e_rdy  = m_ready();
      e_bclk = m_busy && (ph >= D / 2);
      e_le   = m_busy && (slot >= LEAD);
      e_sd   = m_busy && (slot >= LEAD) && m_word[W - 1 - (slot - LEAD)];
      check(s_ready == e_rdy, "R2", "ready", s_ready, e_rdy);
      check(bclk == e_bclk, m_busy ? "R3" : "R9", "bclk", bclk, e_bclk);
      check(sdata == e_sd, m_busy ? "R4" : "R9", "sdata", sdata, e_sd);
      check(latch_en == e_le, m_busy ? "R6" : "R9", "latch_en", latch_en, e_le);
      if (sdata != prev_sd || latch_en != prev_le)
        check(prev_bclk && !bclk, "R5", "change without bclk fall",
              {prev_bclk, bclk}, 2);
    end
    prev_bclk = bclk;
    prev_sd = sdata;
    prev_le = latch_en;
  end

  // receiver model
  logic [W-1:0] rx = '0;
  int hi_cnt = 0, lo_cnt = 0, n_latched = 0;
  bit seen_fall = 0;

  always @(posedge bclk) begin
    rx = {rx[W-2:0], sdata};
    if (latch_en) hi_cnt++;
    else lo_cnt++;
  end

  always @(negedge latch_en) begin
    if (rst_n) begin
      check(hi_cnt >= 1, "R6", "bclk rises while strobe high", hi_cnt, 1);
      if (expq.size() == 0) check(0, "R8", "latch with no sample", rx, 0);
      else begin
        logic [W-1:0] e;
        e = expq.pop_front();
        check(rx == e, "R8 R10", "latched word", rx, e);
      end
      n_latched++;
      seen_fall = 1;
      lo_cnt = 0;
    end
  end

  always @(posedge latch_en) begin
    if (rst_n && seen_fall)
      check(lo_cnt >= 1, "R7", "bclk rises while strobe low", lo_cnt, 1);
    hi_cnt = 0;
  end

  task automatic send(input logic [W-1:0] d);
    s_valid = 1'b1;
    s_data = d;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R8: full-scale and zero-crossing codes back to back (R2 ready window)
    send(18'h1FFFF);
    send(18'h00000);
    send(18'h3FFFF);
    send(18'h20000);
    // R9 / R7: idle gap with parked clock
    repeat (60) @(negedge clk);
    // R10: offer a sample while the frame is running, withdraw before ready
    send(18'h2AAAA);
    repeat (10) @(negedge clk);
    s_valid = 1'b1;
    s_data = 18'h15555;
    repeat (30) @(negedge clk);
    s_valid = 1'b0;
    while (!s_ready) @(negedge clk);
    repeat (7) @(negedge clk);
    // a few computed patterns
    for (int i = 0; i < 3; i++) send(W'(32'h0A5C3 * (i + 3) ^ (i << 11)));
    repeat (FC + 20) @(negedge clk);
    check(expq.size() == 0, "R8", "words still pending", expq.size(), 0);
    check(n_latched == n_sent && n_sent == 8, "R10", "latched count",
          n_latched, 8);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(0, "R2", "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

endmodule